// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between a memory command scheduler and a multi-bank SDRAM command bus. For each bank it keeps an open/idle flag and the row held open, together with cycle counters that measure how long ago the bank, and any bank, was last activated. A scheduler presents one request per cycle: an activate, read, write or precharge, with a bank and a row. In the same cycle the guard answers with either a grant or a violation flag and a code that says why.

Only a granted request changes the tracked state. A refused request leaves every flag, row and counter as it was, so the scheduler can retry later. The guard enforces three activate-related intervals at once: activate-to-access within a bank (`T_RCD`), activate-to-activate within a bank (`T_RC`) and activate-to-activate across banks (`T_RRD`). All three are parameters in clock cycles.

Top module: `act_guard`

## Requirements
- R1: After reset every bank is idle (`bank_open` all zero), and every interval counts as expired, so an activate in the first cycle is granted.
- R2: Commands are encoded as 0 activate, 1 read, 2 write and 3 precharge. With `req_valid` high, exactly one of `grant` and `viol` is high. With `req_valid` low, both are low and `viol_code` is 0.
- R3: A granted activate opens the given row in the given bank. From the next cycle, `bank_open` shows that bank as open.
- R4: A read or write to an idle bank is refused with code 1.
- R5: A read or write to an open bank whose row differs from the open row is refused with code 2 (row miss).
- R6: An activate to a bank that already has a row open, with the same row or another, is refused with code 3.
- R7: An activate to a bank less than `T_RC` cycles after that bank's previous granted activate is refused with code 4.
- R8: An activate less than `T_RRD` cycles after the last granted activate to any bank is refused with code 5.
- R9: A read or write to the open row less than `T_RCD` cycles after that bank's activate is refused with code 6. At exactly `T_RCD` cycles it is granted.
- R10: A precharge is always granted. It returns an open bank to idle from the next cycle and has no effect on an idle bank.
- R11: A refused request changes no state: `bank_open`, the open rows and every interval counter are left as they were.
- R12: When several faults apply, the lowest-numbered check wins. For an activate: open bank (3), then `T_RC` (4), then `T_RRD` (5). For a read or write: idle bank (1), then row miss (2), then `T_RCD` (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_cmd | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row address (activate, read, write) |
| grant | output | 1 | Request may issue this cycle |
| viol | output | 1 | Request is illegal this cycle |
| viol_code | output | 3 | Reason for refusal, 0 when none |
| bank_open | output | NB | One bit per bank, high while a row is open |

## Verification
If the stored row is wrong, the next read or write to that bank shows it in the same cycle, as a false row miss or a false grant. If an open flag is wrong, it shows on `bank_open` one cycle after the command that corrupted it. A counter that is loaded or decremented wrongly stays hidden until a request lands in its window, so the bench keeps the request stream dense around activates. It probes the exact boundary cycles, where a granted or refused request is decided by a single cycle.

// File: rtl/act_guard.sv
module act_guard #(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RC  = 10,
  parameter int T_RRD = 2,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  output logic              grant,
  output logic              viol,
  output logic [2:0]        viol_code,
  output logic [NB-1:0]     bank_open
);
  localparam int TMAX = (T_RC > T_RCD) ? ((T_RC > T_RRD) ? T_RC : T_RRD)
                                       : ((T_RCD > T_RRD) ? T_RCD : T_RRD);
  localparam int CW = $clog2(TMAX + 1);

  localparam logic [1:0] C_ACT = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_PRE = 2'd3;

  logic [NB-1:0]    open_q;
  logic [ROW_W-1:0] row_q [NB];
  logic [CW-1:0]    rcd_q [NB];
  logic [CW-1:0]    rc_q  [NB];
  logic [CW-1:0]    rrd_q;
  logic [2:0]       code;

  wire sel_open = open_q[req_bank];
  wire row_hit  = row_q[req_bank] == req_row;

  always_comb begin
    code = 3'd0;
    case (req_cmd)
      C_ACT: begin
        if (sel_open)                 code = 3'd3;
        else if (rc_q[req_bank] != 0) code = 3'd4;
        else if (rrd_q != 0)          code = 3'd5;
      end
      C_RD, C_WR: begin
        if (!sel_open)                 code = 3'd1;
        else if (!row_hit)             code = 3'd2;
        else if (rcd_q[req_bank] != 0) code = 3'd6;
      end
      default: code = 3'd0;
    endcase
  end

  assign grant     = req_valid && code == 3'd0;
  assign viol      = req_valid && code != 3'd0;
  assign viol_code = req_valid ? code : 3'd0;
  assign bank_open = open_q;

  wire act_ok = grant && req_cmd == C_ACT;
  wire pre_ok = grant && req_cmd == C_PRE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      rrd_q  <= '0;
      for (int b = 0; b < NB; b++) begin
        row_q[b] <= '0;
        rcd_q[b] <= '0;
        rc_q[b]  <= '0;
      end
    end else begin
      rrd_q <= act_ok ? CW'(T_RRD - 1) : (rrd_q != 0 ? rrd_q - 1'b1 : rrd_q);
      for (int b = 0; b < NB; b++) begin
        if (act_ok && req_bank == BANK_W'(b)) begin
          open_q[b] <= 1'b1;
          row_q[b]  <= req_row;
          rcd_q[b]  <= CW'(T_RCD - 1);
          rc_q[b]   <= CW'(T_RC - 1);
        end else begin
          if (pre_ok && req_bank == BANK_W'(b)) open_q[b] <= 1'b0;
          if (rcd_q[b] != 0) rcd_q[b] <= rcd_q[b] - 1'b1;
          if (rc_q[b] != 0)  rc_q[b]  <= rc_q[b] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/act_guard_chk.sv
module act_guard_chk #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int T_RRD  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic              grant,
  input logic              viol,
  input logic [NB-1:0]     bank_open
);
  localparam int GW = $clog2(T_RRD + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= GW'(T_RRD);
    else if (grant && req_cmd == 2'd0) gap <= GW'(1);
    else if (gap < GW'(T_RRD)) gap <= gap + 1'b1;
  end

  assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({grant, viol}) == 1);

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !grant && !viol);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_cmd == 2'd0 |=> bank_open[$past(req_bank)]);

  assert_access_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant && (req_cmd == 2'd1 || req_cmd == 2'd2) |-> bank_open[req_bank]);

  assert_rrd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_cmd == 2'd0 |-> gap >= GW'(T_RRD));

  assert_pre_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant && req_cmd == 2'd3 |=> !bank_open[$past(req_bank)]);

  assert_refused_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> $stable(bank_open));
endmodule

bind act_guard act_guard_chk #(.NB(NB), .BANK_W(BANK_W), .T_RRD(T_RRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_bank(req_bank), .grant(grant), .viol(viol), .bank_open(bank_open)
);

// File: tb/act_guard_tb.sv
module act_guard_tb;
  localparam int NB = 4, ROW_W = 13, T_RCD = 3, T_RC = 10, T_RRD = 2;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_cmd = 0;
  logic [1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic grant, viol;
  logic [2:0] viol_code;
  logic [NB-1:0] bank_open;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_open [NB];
  int m_row [NB];
  int m_act [NB];
  int m_any;

  always #10 clk = ~clk;

  act_guard #(.NB(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .grant(grant), .viol(viol),
    .viol_code(viol_code), .bank_open(bank_open));

  function automatic int exp_code(int c, int b, int r);
    if (c == 0) begin
      if (m_open[b]) return 3;
      if (cyc - m_act[b] < T_RC) return 4;
      if (cyc - m_any < T_RRD) return 5;
      return 0;
    end else if (c == 3) return 0;
    if (!m_open[b]) return 1;
    if (m_row[b] != r) return 2;
    if (cyc - m_act[b] < T_RCD) return 6;
    return 0;
  endfunction

  function automatic string tag(int code, int c);
    case (code)
      1: return "R4"; 2: return "R5"; 3: return "R6"; 4: return "R7";
      5: return "R8"; 6: return "R9";
      default: return (c == 3) ? "R10" : "R3";
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_open();
    logic [NB-1:0] v;
    for (int b = 0; b < NB; b++) v[b] = m_open[b];
    return v;
  endfunction

  task automatic chk(bit ok, string rq, int act, int ex);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, ex, cyc);
    end
  endtask

  task automatic step(bit v, int c, int b, int r);
    int e;
    @(negedge clk);
    req_valid = v; req_cmd = 2'(c); req_bank = 2'(b); req_row = ROW_W'(r);
    #2;
    chk(bank_open == exp_open(), "R11 bank_open", int'(bank_open), int'(exp_open()));
    if (!v) begin
      chk(!grant && !viol && viol_code == 0, "R2 idle", {grant, viol, viol_code}, 0);
    end else begin
      e = exp_code(c, b, r);
      chk(int'(viol_code) == e, tag(e, c), viol_code, e);
      chk(grant == (e == 0) && viol == (e != 0), "R2 answer", {grant, viol}, (e == 0) ? 2 : 1);
      if (e == 0) begin
        if (c == 0) begin m_open[b] = 1; m_row[b] = r; m_act[b] = cyc; m_any = cyc; end
        if (c == 3) m_open[b] = 0;
      end
    end
    cyc++;
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_act[b] = -1000; end
    m_any = -1000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: idle after reset, activate granted at once
    step(0, 0, 0, 0);
    step(1, 0, 0, 5);
    step(1, 1, 0, 5);   // R9 early
    step(0, 0, 0, 0);
    step(1, 2, 0, 5);   // R9 exact boundary
    step(1, 1, 0, 6);   // R5
    step(1, 0, 1, 1);
    step(1, 0, 2, 1);   // R8
    step(1, 0, 0, 5);   // R6 / R12
    step(1, 3, 0, 0);   // R10
    step(1, 0, 0, 7);   // R7
    step(1, 1, 3, 0);   // R4
    step(1, 3, 3, 0);   // R10 idle
    step(1, 0, 2, 2);
    for (int i = 0; i < 4000; i++) begin
      int c = $urandom_range(0, 9);
      step($urandom_range(0, 4) != 0, c < 3 ? 0 : (c < 6 ? 1 + (c & 1) : (c < 8 ? 3 : 1)),
           $urandom_range(0, NB - 1), $urandom_range(0, 2));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule